// File: doc/BRIEF.md
# Multi-Mode Tone Buzzer Generator

This block drives a single buzzer pin with a square-wave tone. A 3-bit select picks one of eight tone pitches between 0.625 kHz and 3 kHz. A 2-bit mode select picks one of four cadences that gate the tone:
- steady sound;
- one fixed-length burst per trigger;
- a 10 Hz on/off beat;
- the 10 Hz beat sounding for half of each second and silent for the other half.

All cadence timing comes from the system clock through two parameters. `TONE_UNIT` is the number of clocks in one tone multiplier unit. `GATE_TICK` is the number of clocks in a 50 ms slot.

The block has no data stream, so there is no valid/ready interface. Every pin is a plain control level or strobe. A slot counter runs freely from reset and sets the cadence phase. The output changes only when a tone half-period ends, or when the block is disabled. A new select or mode value is therefore picked up cleanly, and no pulse is ever shorter than a whole half-period.

Top module: `buzz_gen`

## Requirements
- R1: While `rst_n` is low, `buzz_o` is low. After release, the slot counter starts at slot 0 on the first clock edge.
- R2: The tone half-period for `sel` values 0..7 is `TONE_UNIT` times 20, 25, 30, 40, 50, 60, 80 and 96 clocks respectively. With default parameters this gives 3000, 2400, 2000, 1500, 1200, 1000, 750 and 625 Hz.
- R3: Mode 0 (steady) gates the tone on for as long as `en` is high.
- R4: Mode 1 (shot) gates the tone on for `2*GATE_TICK` clocks after a `fire` strobe taken while `en` is high. A new strobe restarts the window. When the window ends, the output falls to low and stays low.
- R5: Mode 2 (beat) gates the tone on during even-numbered slots and off during odd-numbered slots. A slot lasts `GATE_TICK` clocks.
- R6: Mode 3 (grouped beat) numbers slots 0..19 in a repeating cycle. It gates the tone on only in even slots below 10.
- R7: While `en` is low, `buzz_o` is low from the next clock edge onward. A `fire` strobe taken while `en` is low has no effect. Re-enabling does not start a burst.
- R8: `sel` and `mode` are sampled only at the end of a tone half-period. Each high pulse on `buzz_o` lasts exactly one half-period of the `sel` value sampled when the pulse started.
- R9: While `en` stays high, `buzz_o` changes only on the clock after a tone half-period ends. It is driven high for a half-period only if the gate for the current mode is open at that boundary and the tone is entering its high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Block enable; low forces the output low |
| fire | input | 1 | Single-cycle trigger for the shot mode |
| mode | input | 2 | Cadence: 0 steady, 1 shot, 2 beat, 3 grouped beat |
| sel | input | 3 | Tone pitch select, 0 highest to 7 lowest |
| buzz_o | output | 1 | Gated square-wave buzzer output |

## Verification
Steady mode is run at every pitch. The measured rise-to-rise spacing separates the eight half-period multipliers from one another. Pitch and mode are changed at arbitrary cycles, which shows whether a change is taken at the half-period boundary or taken at once and leaves a runt pulse. The beat and grouped modes run across several full one-second cycles, so an even/odd slot swap or a missing silent half would show up. Shot mode is exercised with a single strobe, a retrigger in mid-burst, and a strobe given while disabled, which together separate window length, restart and enable qualification.

// File: rtl/buzz_pkg.sv
package buzz_pkg;

  typedef enum logic [1:0] {
    BZ_STEADY = 2'd0,
    BZ_SHOT   = 2'd1,
    BZ_BEAT   = 2'd2,
    BZ_GROUP  = 2'd3
  } bz_mode_e;

  localparam int SLOTS_PER_CYCLE = 20;
  localparam int GROUP_SLOTS     = 10;
  localparam int SHOT_SLOTS      = 2;
  localparam int MAX_MULT        = 96;

  // tone half-period multipliers, highest pitch first
  function automatic int half_mult(input logic [2:0] s);
    case (s)
      3'd0:    half_mult = 20;
      3'd1:    half_mult = 25;
      3'd2:    half_mult = 30;
      3'd3:    half_mult = 40;
      3'd4:    half_mult = 50;
      3'd5:    half_mult = 60;
      3'd6:    half_mult = 80;
      default: half_mult = 96;
    endcase
  endfunction

endpackage

// File: rtl/buzz_timebase.sv
module buzz_timebase #(
  parameter int GATE_TICK = 6250000
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [4:0] slot_o
);
  import buzz_pkg::*;

  localparam int TW = (GATE_TICK > 1) ? $clog2(GATE_TICK) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(GATE_TICK - 1);
  localparam logic [4:0]    SLOT_LAST = 5'(SLOTS_PER_CYCLE - 1);

  logic [TW-1:0] tick_cnt;
  logic          tick_wrap;

  assign tick_wrap = (tick_cnt == TICK_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      slot_o   <= '0;
    end else if (tick_wrap) begin
      tick_cnt <= '0;
      slot_o   <= (slot_o == SLOT_LAST) ? 5'd0 : slot_o + 5'd1;
    end else begin
      tick_cnt <= tick_cnt + TW'(1);
    end
  end

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_o <= SLOT_LAST); // R6
  AST_SLOT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_wrap |=> $stable(slot_o)); // R5

endmodule

// File: rtl/buzz_gate.sv
module buzz_gate #(
  parameter int GATE_TICK = 6250000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               fire,
  input  buzz_pkg::bz_mode_e mode,
  input  logic [4:0]         slot,
  output logic               gate_o
);
  import buzz_pkg::*;

  localparam int SHOT_LEN = SHOT_SLOTS * GATE_TICK;
  localparam int SW = $clog2(SHOT_LEN + 1);
  localparam logic [SW-1:0] SHOT_LOAD = SW'(SHOT_LEN - 1);
  localparam logic [4:0]    GROUP_END = 5'(GROUP_SLOTS);

  logic [SW-1:0] shot_cnt;
  logic          busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shot_cnt <= '0;
      busy     <= 1'b0;
    end else if (!en) begin
      shot_cnt <= '0;
      busy     <= 1'b0;
    end else if (fire) begin
      shot_cnt <= SHOT_LOAD;
      busy     <= 1'b1;
    end else if (busy) begin
      if (shot_cnt == '0) busy <= 1'b0;
      else                shot_cnt <= shot_cnt - SW'(1);
    end
  end

  always_comb begin
    case (mode)
      BZ_STEADY: gate_o = 1'b1;
      BZ_SHOT:   gate_o = busy;
      BZ_BEAT:   gate_o = ~slot[0];
      default:   gate_o = ~slot[0] && (slot < GROUP_END);
    endcase
  end

  AST_FIRE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fire) |=> busy); // R4
  AST_SHOT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !fire && busy && shot_cnt == '0) |=> !busy); // R4
  AST_IDLE_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy); // R7

endmodule

// File: rtl/buzz_tone.sv
module buzz_tone #(
  parameter int TONE_UNIT = 1042
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel_i,
  output logic       bound_o,
  output logic       phase_o
);
  import buzz_pkg::*;

  localparam int MAXH = TONE_UNIT * MAX_MULT;
  localparam int CW   = $clog2(MAXH + 1);

  logic [CW-1:0] cnt;
  logic [2:0]    act_sel;

  function automatic logic [CW-1:0] reload(input logic [2:0] s);
    reload = CW'(TONE_UNIT * half_mult(s) - 1);
  endfunction

  assign bound_o = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      act_sel <= '0;
      phase_o <= 1'b0;
    end else if (bound_o) begin
      cnt     <= reload(sel_i);
      act_sel <= sel_i;
      phase_o <= ~phase_o;
    end else begin
      cnt     <= cnt - CW'(1);
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= reload(act_sel)); // R2
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bound_o |=> $stable(phase_o)); // R8

endmodule

// File: rtl/buzz_gen.sv
module buzz_gen #(
  parameter int TONE_UNIT = 1042,
  parameter int GATE_TICK = 6250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       fire,
  input  logic [1:0] mode,
  input  logic [2:0] sel,
  output logic       buzz_o
);
  import buzz_pkg::*;

  logic [4:0] slot;
  logic       gate;
  logic       bound;
  logic       phase;
  bz_mode_e   mode_e;

  assign mode_e = bz_mode_e'(mode);

  buzz_timebase #(.GATE_TICK(GATE_TICK)) u_tb (
    .clk(clk), .rst_n(rst_n), .slot_o(slot)
  );

  buzz_gate #(.GATE_TICK(GATE_TICK)) u_gate (
    .clk(clk), .rst_n(rst_n), .en(en), .fire(fire),
    .mode(mode_e), .slot(slot), .gate_o(gate)
  );

  buzz_tone #(.TONE_UNIT(TONE_UNIT)) u_tone (
    .clk(clk), .rst_n(rst_n), .sel_i(sel),
    .bound_o(bound), .phase_o(phase)
  );

  // output moves only at half-period ends, or drops at once on disable
  always_ff @(posedge clk) begin
    if (!rst_n)     buzz_o <= 1'b0;
    else if (!en)   buzz_o <= 1'b0;
    else if (bound) buzz_o <= gate & ~phase;
  end

  AST_DIS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !buzz_o); // R7
  AST_EDGE_AT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bound) |=> $stable(buzz_o)); // R9
  AST_HIGH_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    buzz_o |-> phase); // R8

endmodule

// File: tb/buzz_gen_test.sv
module buzz_gen_test;
  localparam int TU = 1;
  localparam int GT = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic fire = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [2:0] sel = 3'd0;
  logic buzz_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  buzz_gen #(.TONE_UNIT(TU), .GATE_TICK(GT)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .fire(fire),
    .mode(mode), .sel(sel), .buzz_o(buzz_o)
  );

  function automatic int mult(input int s);
    int t[8] = '{20, 25, 30, 40, 50, 60, 80, 96};
    return t[s];
  endfunction

  // behavioural reference model
  int k, tleft, srem, slot_m, run_len, run_exp, cur_half;
  bit mph, mout, g;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      k = 0; tleft = 0; mph = 0; mout = 0; srem = 0;
    end else begin
      slot_m = (k / GT) % 20;
      case (mode)
        2'd0: g = 1;
        2'd1: g = (srem > 0);
        2'd2: g = (slot_m % 2 == 0);
        default: g = (slot_m < 10) && (slot_m % 2 == 0);
      endcase
      if (!en) mout = 0;
      else if (tleft == 0) begin
        if (g && !mph) run_exp = mult(sel) * TU;
        mout = g && !mph;
      end
      if (!en) srem = 0;
      else if (fire) srem = 2 * GT;
      else if (srem > 0) srem--;
      if (tleft == 0) begin
        tleft = mult(sel) * TU - 1;
        mph = !mph;
      end else tleft--;
      k++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // every-clock comparison and pulse-width monitor
  bit prev_b = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      string tag;
      if (!en) tag = "R7";
      else case (mode)
        2'd0: tag = "R3";
        2'd1: tag = "R4";
        2'd2: tag = "R5";
        default: tag = "R6";
      endcase
      check(buzz_o === mout, tag, buzz_o, mout);
      if (buzz_o && !prev_b) begin run_len = 1; cur_half = run_exp; end
      else if (buzz_o) run_len++;
      else if (prev_b && en) check(run_len == cur_half, "R8 pulse width", run_len, cur_half);
      prev_b = buzz_o;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic next_rise(output int t);
    bit p;
    p = buzz_o;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (buzz_o && !p) break;
      p = buzz_o;
    end
    t = cyc;
  endtask

  initial begin
    int t0, t1, hi;
    step(3);
    check(buzz_o === 1'b0, "R1 reset low", buzz_o, 0);
    rst_n = 1'b1;
    step(2);
    check(buzz_o === 1'b0, "R1 disabled after reset", buzz_o, 0);

    // pitch sweep in steady mode
    en = 1'b1; mode = 2'd0;
    for (int s = 0; s < 8; s++) begin
      sel = 3'(s);
      next_rise(t0); next_rise(t0); next_rise(t1);
      check(t1 - t0 == 2 * TU * mult(s), "R2 tone period", t1 - t0, 2 * TU * mult(s));
    end

    // mid-half-period changes of pitch (R8)
    sel = 3'd2; step(37); sel = 3'd5; step(13); sel = 3'd0; step(211);

    // beat mode and grouped mode over full cycles
    mode = 2'd2; sel = 3'd1; step(1700);
    mode = 2'd3; sel = 3'd0; step(8200);
    mode = 2'd0; step(23); mode = 2'd3; step(51); sel = 3'd4; step(300);

    // shot mode: single burst, then retrigger
    mode = 2'd1; sel = 3'd0; step(100);
    fire = 1'b1; step(1); fire = 1'b0;
    step(2 * GT + 200);
    check(buzz_o === 1'b0, "R4 low after burst", buzz_o, 0);
    fire = 1'b1; step(1); fire = 1'b0;
    step(250);
    fire = 1'b1; step(1); fire = 1'b0;
    hi = 0;
    for (int i = 0; i < 2 * GT + 200; i++) begin
      step(1);
      if (i > 2 * GT - 250 && i < 2 * GT - 60 && buzz_o) hi++;
    end
    check(hi > 0, "R4 retrigger extends", hi, 1);
    check(buzz_o === 1'b0, "R4 low after retrigger", buzz_o, 0);

    // strobe while disabled is ignored
    en = 1'b0; fire = 1'b1; step(1); fire = 1'b0; step(5);
    en = 1'b1; hi = 0;
    for (int i = 0; i < 3 * GT; i++) begin step(1); if (buzz_o) hi++; end
    check(hi == 0, "R7 fire ignored when disabled", hi, 0);

    // disable during steady tone
    mode = 2'd0; sel = 3'd7;
    next_rise(t0); step(5);
    en = 1'b0; step(1);
    check(buzz_o === 1'b0, "R7 disable forces low", buzz_o, 0);
    step(300);
    en = 1'b1; step(500);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule